// File: doc/BRIEF.md
# SPI Pad Steering and Serial Clock Divider

This block sits between the pads of an SPI port and its shift logic. It takes the port's role (master or slave), a single-wire bidirectional mode bit, one direction bit per pad (MISO, MOSI, SCK, SS), an enable for driving the select line, and the current level of the SS pad. From these it works out which pads are driven, which data pad the shift logic samples, and which pad is handed back to general-purpose use.

It also holds a 3-bit clock rate register and divides the bus clock down to a one-cycle serial clock tick that is used while the port is a master. The divisor is a power of two from 2 to 256. A new rate takes effect only at the end of the period that is running, so the tick spacing never tears. The divider is held cleared in slave mode and starts from zero each time master mode is entered.

Top module: `spi_pad_front`

## Requirements
- R1: With the bidirectional bit at 0, a master samples MISO (`serInFromMosi`=0) and a slave samples MOSI (`serInFromMosi`=1). Neither `misoGpio` nor `mosiGpio` is set.
- R2: With the bidirectional bit at 1 in master mode, MOSI is the only data pin and is sampled (`serInFromMosi`=1). MISO is handed back to general-purpose use (`misoGpio`=1, `mosiGpio`=0).
- R3: With the bidirectional bit at 1 in slave mode, MISO is the only data pin and is sampled (`serInFromMosi`=0). MOSI is handed back to general-purpose use (`mosiGpio`=1, `misoGpio`=0).
- R4: `misoOe` is 1 exactly when the MISO direction bit is 1, `ssInN` is 0 and the role is slave.
- R5: `mosiOe` is 1 exactly when the MOSI direction bit is 1 and the role is master.
- R6: `sckOe` is 1 exactly when the SCK direction bit is 1 and the role is master.
- R7: `ssOe` is 1 exactly when the SS direction bit, `ssOutEn` and the master role are all 1.
- R8: In master mode with rate code r (0..7) in force, `sckTick` is high for one cycle in every 2^(r+1) cycles.
- R9: After reset the rate register reads 0. A write with `rateWe` high is visible on `rateQ` from the next cycle.
- R10: A rate written while master mode is running takes effect only after the next tick. The period in progress keeps its old length.
- R11: On entering master mode, the first tick comes 2^(r+1)-1 cycles after the cycle in which `masterMode` rises.
- R12: In slave mode `sckTick` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterMode | input | 1 | 1 = master role, 0 = slave role |
| biDir | input | 1 | Single-wire bidirectional data mode |
| dirMiso | input | 1 | Direction bit of the MISO pad |
| dirMosi | input | 1 | Direction bit of the MOSI pad |
| dirSck | input | 1 | Direction bit of the SCK pad |
| dirSs | input | 1 | Direction bit of the SS pad |
| ssOutEn | input | 1 | Lets the master drive SS |
| ssInN | input | 1 | Level seen on the SS pad (active low) |
| rateWe | input | 1 | Write strobe for the rate register |
| rateWrData | input | 3 | Rate code to write |
| rateQ | output | 3 | Rate register contents |
| misoOe | output | 1 | MISO output enable |
| mosiOe | output | 1 | MOSI output enable |
| sckOe | output | 1 | SCK output enable |
| ssOe | output | 1 | SS output enable |
| serInFromMosi | output | 1 | Shift input taken from MOSI (1) or MISO (0) |
| misoGpio | output | 1 | MISO handed to general-purpose use |
| mosiGpio | output | 1 | MOSI handed to general-purpose use |
| sckTick | output | 1 | One-cycle serial clock enable tick |

## Verification
The pad enables and routing flags are purely combinational, so the bench checks them in the same cycle as the stimulus. It drives the inputs just after a falling edge and samples them 1 ns later, across all 256 combinations of role, mode, direction bits, `ssOutEn` and `ssInN`. A rate write becomes visible on `rateQ` after one rising edge. The divider tick depends on registered state, so the bench counts falling-edge samples from the point where master mode is entered or the previous tick was seen. It expects the first tick at sample 2^(r+1)-1 and each later one 2^(r+1) samples apart. When the rate is changed in the middle of a period, the interval that is running must still have the old length.

// File: rtl/spi_pad_pkg.sv
package spi_pad_pkg;
  typedef struct packed {
    logic cntClear;
    logic cntWrap;
  } divStrobe_t;
endpackage

// File: rtl/spi_pad_ctrl.sv
module spi_pad_ctrl
  import spi_pad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterMode,
  input  logic       biDir,
  input  logic       dirMiso,
  input  logic       dirMosi,
  input  logic       dirSck,
  input  logic       dirSs,
  input  logic       ssOutEn,
  input  logic       ssInN,
  input  logic       termHit,
  output divStrobe_t strobe,
  output logic       misoOe,
  output logic       mosiOe,
  output logic       sckOe,
  output logic       ssOe,
  output logic       serInFromMosi,
  output logic       misoGpio,
  output logic       mosiGpio
);
  always_comb begin
    misoOe        = !masterMode && dirMiso && !ssInN;
    mosiOe        = masterMode && dirMosi;
    sckOe         = masterMode && dirSck;
    ssOe          = masterMode && dirSs && ssOutEn;
    serInFromMosi = !(masterMode ^ biDir);
    misoGpio      = masterMode && biDir;
    mosiGpio      = !masterMode && biDir;
    strobe.cntClear = !masterMode;
    strobe.cntWrap  = masterMode && termHit;
  end

  assert_miso_slave_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> (!masterMode && !ssInN));
  assert_mosi_master_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    mosiOe |-> masterMode);
  assert_ss_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    ssOe |-> (ssOutEn && dirSs));
  assert_one_gpio_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(misoGpio && mosiGpio));
  assert_no_tick_slave_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntWrap |-> masterMode);
endmodule

// File: rtl/spi_pad_div.sv
module spi_pad_div
  import spi_pad_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        strobe,
  input  logic              rateWe,
  input  logic [RATE_W-1:0] rateWrData,
  output logic [RATE_W-1:0] rateQ,
  output logic              termHit
);
  localparam int CNT_W = 2 ** RATE_W;
  localparam int SH_W  = RATE_W + 1;

  logic [RATE_W-1:0] rateReg;
  logic [RATE_W-1:0] activeRate;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    divisor;
  logic [CNT_W-1:0]  termCnt;
  logic [SH_W-1:0]   shiftAmt;

  always_comb begin
    shiftAmt = SH_W'(activeRate) + SH_W'(1);
    divisor  = (CNT_W+1)'(1) << shiftAmt;
    termCnt  = CNT_W'(divisor - (CNT_W+1)'(1));
    termHit  = (cnt == termCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rateReg <= '0;
    else if (rateWe) rateReg <= rateWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      activeRate <= '0;
    end else if (strobe.cntClear || strobe.cntWrap) begin
      cnt        <= '0;
      activeRate <= rateReg;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign rateQ = rateReg;

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= termCnt);
  assert_rate_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.cntClear) && !$past(strobe.cntWrap)) |-> $stable(activeRate));
  assert_clear_slave_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> (cnt == '0));
endmodule

// File: rtl/spi_pad_front.sv
module spi_pad_front
  import spi_pad_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              biDir,
  input  logic              dirMiso,
  input  logic              dirMosi,
  input  logic              dirSck,
  input  logic              dirSs,
  input  logic              ssOutEn,
  input  logic              ssInN,
  input  logic              rateWe,
  input  logic [RATE_W-1:0] rateWrData,
  output logic [RATE_W-1:0] rateQ,
  output logic              misoOe,
  output logic              mosiOe,
  output logic              sckOe,
  output logic              ssOe,
  output logic              serInFromMosi,
  output logic              misoGpio,
  output logic              mosiGpio,
  output logic              sckTick
);
  divStrobe_t strobe;
  logic       termHit;

  spi_pad_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .biDir(biDir),
    .dirMiso(dirMiso), .dirMosi(dirMosi), .dirSck(dirSck), .dirSs(dirSs),
    .ssOutEn(ssOutEn), .ssInN(ssInN), .termHit(termHit), .strobe(strobe),
    .misoOe(misoOe), .mosiOe(mosiOe), .sckOe(sckOe), .ssOe(ssOe),
    .serInFromMosi(serInFromMosi), .misoGpio(misoGpio), .mosiGpio(mosiGpio)
  );

  spi_pad_div #(.RATE_W(RATE_W)) uDiv (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rateWe(rateWe),
    .rateWrData(rateWrData), .rateQ(rateQ), .termHit(termHit)
  );

  assign sckTick = strobe.cntWrap;
endmodule

// File: tb/tb_spi_pad_front.sv
module tb_spi_pad_front;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 0, biDir = 0, dirMiso = 0, dirMosi = 0, dirSck = 0, dirSs = 0;
  logic ssOutEn = 0, ssInN = 1, rateWe = 0;
  logic [2:0] rateWrData = '0;
  logic [2:0] rateQ;
  logic misoOe, mosiOe, sckOe, ssOe, serInFromMosi, misoGpio, mosiGpio, sckTick;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_pad_front dut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .biDir(biDir),
    .dirMiso(dirMiso), .dirMosi(dirMosi), .dirSck(dirSck), .dirSs(dirSs),
    .ssOutEn(ssOutEn), .ssInN(ssInN), .rateWe(rateWe), .rateWrData(rateWrData),
    .rateQ(rateQ), .misoOe(misoOe), .mosiOe(mosiOe), .sckOe(sckOe), .ssOe(ssOe),
    .serInFromMosi(serInFromMosi), .misoGpio(misoGpio), .mosiGpio(mosiGpio),
    .sckTick(sckTick)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic stepNeg();
    @(negedge clk); #1;
  endtask

  task automatic cyclesToTick(output int n);
    n = 0;
    while (!sckTick && n < 1000) begin stepNeg(); n++; end
  endtask

  task automatic writeRate(input logic [2:0] r);
    @(negedge clk); rateWe = 1; rateWrData = r;
    @(negedge clk); rateWe = 0; #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int div;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R9 reset value
    check("R9 reset rate", rateQ, 0);
    check("R6 reset sckOe", sckOe, 0);

    // Exhaustive pad sweep: R1..R7
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      {masterMode, biDir, dirMiso, dirMosi, dirSck, dirSs, ssOutEn, ssInN} = c[7:0];
      #1;
      check("R4 misoOe", misoOe, int'(!masterMode && dirMiso && !ssInN));
      check("R5 mosiOe", mosiOe, int'(masterMode && dirMosi));
      check("R6 sckOe", sckOe, int'(masterMode && dirSck));
      check("R7 ssOe", ssOe, int'(masterMode && dirSs && ssOutEn));
      if (!biDir) begin
        check("R1 serIn", serInFromMosi, masterMode ? 0 : 1);
        check("R1 gpio", {misoGpio, mosiGpio}, 0);
      end else if (masterMode) begin
        check("R2 serIn", serInFromMosi, 1);
        check("R2 gpio", {misoGpio, mosiGpio}, 2);
      end else begin
        check("R3 serIn", serInFromMosi, 0);
        check("R3 gpio", {misoGpio, mosiGpio}, 1);
      end
    end

    // R12 slave mode: no ticks
    @(negedge clk); masterMode = 0; #1;
    n = 0;
    for (int i = 0; i < 600; i++) begin
      if (sckTick) n++;
      stepNeg();
    end
    check("R12 slave ticks", n, 0);

    // R8/R11 every rate code
    for (int r = 0; r < 8; r++) begin
      writeRate(3'(r));
      check("R9 readback", rateQ, r);
      div = 1 << (r + 1);
      @(negedge clk); masterMode = 1; #1;
      cyclesToTick(n);
      check("R11 first tick", n, div - 1);
      for (int k = 0; k < 2; k++) begin
        stepNeg();
        cyclesToTick(n);
        check("R8 period", n + 1, div);
      end
      @(negedge clk); masterMode = 0; #1;
    end

    // R10 mid-period change from code 7 to code 0
    writeRate(3'd7);
    @(negedge clk); masterMode = 1; #1;
    cyclesToTick(n);
    check("R11 first tick r7", n, 255);
    @(negedge clk); rateWe = 1; rateWrData = 3'd0;
    @(negedge clk); rateWe = 0; #1;
    cyclesToTick(n);
    check("R10 old period kept", n + 2, 256);
    stepNeg();
    cyclesToTick(n);
    check("R10 new period", n + 1, 2);
    @(negedge clk); masterMode = 0; #1;
    check("R12 tick off", sckTick, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule